// File: doc/BRIEF.md
# Sixteen-bit timer/counter with glitch-free PWM

The block is a 16-bit timer/counter driven by a selectable time base: stopped, the system clock, one of four taps of a shared 10-bit prescaler, or edges on an external clock pin. In normal mode it counts upward and wraps. Two compare channels each raise a flag and act on their own output pin on a match. A capture input, with an optional four-sample noise filter, freezes the counter value on a chosen edge.

In PWM mode the counter runs up and down between zero and a TOP of 8, 9 or 10 bits, giving a phase-correct waveform on each compare pin. Compare values written in this mode are parked in a holding register and only become active when the counter arrives at TOP, so a mid-period update cannot produce a runt pulse. Software reaches the block through a one-cycle write strobe with an address and a combinational read port.

Top module: `pwm_timer16`

## Requirements
- R1: After reset every register (control at address 0, counter 1, compare A 2, compare B 3, capture 4, flags 5) reads zero and both compare outputs and all flags are low.
- R2: Control bits [2:0] pick the time base: 0 stops the counter, 1 advances it every cycle, 2/3/4/5 advance it once per 8/64/256/1024 cycles from one free-running 10-bit prescaler.
- R3: Time base 7 counts rising and 6 counts falling edges of the external clock pin, after a two-flop synchronizer; one edge gives one count.
- R4: In normal mode (control bits [4:3] = 0) the counter wraps from 0xFFFF to 0 and sets the overflow flag (flag bit 0); when it steps onto a compare value the channel flag (bit 1 for A, bit 2 for B) is set and the pin toggles, clears or sets for channel mode 1, 2 or 3 (A mode in bits [6:5], B mode in bits [8:7]).
- R5: Control bits [4:3] = 1, 2, 3 select PWM with TOP 0xFF, 0x1FF, 0x3FF; the counter climbs to TOP, then descends to zero, and never exceeds TOP.
- R6: In PWM mode a compare write lands in a holding register that reads back at once, and the active compare value is replaced only when the counter arrives at TOP; in normal mode the write takes effect immediately.
- R7: In PWM mode the overflow flag is set when the counter turns at zero, not at TOP.
- R8: In PWM mode channel mode 2 clears the pin on a match while counting up and sets it on a match while counting down; mode 3 does the opposite, so with compare value C the pin is high for 2*C of every 2*TOP ticks in mode 2.
- R9: On the selected capture edge (control bit 9: 1 rising, 0 falling) the counter value is copied to the capture register and flag bit 3 is set; the other edge has no effect.
- R10: With control bit 10 set, the capture input must hold four equal consecutive samples before an edge is accepted; a shorter pulse is ignored.
- R11: Writing a one to a flag bit clears it; a zero leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ext_clk_pin | input | 1 | External count clock |
| cap_pin | input | 1 | Capture trigger input |
| cmp_out_a | output | 1 | Compare/PWM output, channel A |
| cmp_out_b | output | 1 | Compare/PWM output, channel B |
| irq_flags | output | 4 | Overflow, compare A, compare B, capture flags |

## Verification
A wrong direction bit or TOP value shows up within one PWM slope as a counter read above TOP or a duty cycle off by many ticks over a full period. A compare value loaded too early shows as a match flag at the new value on the same up slope, visible within tens of cycles. A bad filter or edge selector shows directly in the capture flag and register a few cycles after the pin moves. Overflow flagged at the wrong turning point appears at the flag output half a period early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_CK       = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CMPA = 3'd2;
  localparam logic [2:0] A_CMPB = 3'd3;
  localparam logic [2:0] A_CAP  = 3'd4;
  localparam logic [2:0] A_FLG  = 3'd5;

  localparam int FL_OVF  = 0;
  localparam int FL_CMPA = 1;
  localparam int FL_CMPB = 2;
  localparam int FL_CAP  = 3;
  localparam int N_FLAGS = 4;
endpackage

// File: rtl/tmr_clk_gen.sv
module tmr_clk_gen
  import tmr_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_pin,
  output logic     tick
);
  localparam int TAP_N = 4;
  localparam int TAP_LOG [TAP_N] = '{3, 6, 8, PRE_W};

  logic [PRE_W-1:0] pre;
  logic [TAP_N-1:0] tap_tick;
  logic s1, s2, s3;
  logic ext_rise, ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign tap_tick[g] = &pre[TAP_LOG[g]-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
    end
  end
  assign ext_rise = s2 & ~s3;
  assign ext_fall = ~s2 & s3;

  always_comb begin
    unique case (sel)
      CS_STOP:     tick = 1'b0;
      CS_CK:       tick = 1'b1;
      CS_DIV8:     tick = tap_tick[0];
      CS_DIV64:    tick = tap_tick[1];
      CS_DIV256:   tick = tap_tick[2];
      CS_DIV1024:  tick = tap_tick[3];
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = 1'b0;
    endcase
  end

  // R2
  div8_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_DIV8) && tick |=> (sel != CS_DIV8) || !tick);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int NC_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_pin,
  input  logic nc_en,
  input  logic edge_rise,
  output logic trig
);
  logic s1, s2;
  logic [NC_DEPTH-1:0] hist;
  logic filt, filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; hist <= '0; filt <= 1'b0; filt_q <= 1'b0;
    end else begin
      s1     <= cap_pin;
      s2     <= s1;
      hist   <= {hist[NC_DEPTH-2:0], s2};
      filt_q <= filt;
      if (!nc_en)        filt <= s2;
      else if (&hist)    filt <= 1'b1;
      else if (~|hist)   filt <= 1'b0;
    end
  end

  assign trig = edge_rise ? (filt & ~filt_q) : (~filt & filt_q);

  // R10
  nc_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nc_en && $past(nc_en) && trig |-> ($past(hist) == {NC_DEPTH{filt}}));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm_on,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  input  logic         load_evt,
  input  logic         adv,
  input  logic [W-1:0] cnt_nxt,
  input  logic         move_up,
  input  logic [1:0]   mode,
  output logic         match,
  output logic         out_pin,
  output logic [W-1:0] hold_val
);
  logic [W-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_val <= '0;
      act      <= '0;
    end else begin
      if (wr_cmp) hold_val <= wr_data;
      if (wr_cmp && !pwm_on) act <= wr_data;
      else if (load_evt)     act <= hold_val;
    end
  end

  assign match = adv && (cnt_nxt == act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_pin <= 1'b0;
    else if (match) begin
      if (pwm_on) begin
        if (mode == 2'd2)      out_pin <= ~move_up;
        else if (mode == 2'd3) out_pin <= move_up;
      end else begin
        unique case (mode)
          2'd1:    out_pin <= ~out_pin;
          2'd2:    out_pin <= 1'b0;
          2'd3:    out_pin <= 1'b1;
          default: out_pin <= out_pin;
        endcase
      end
    end
  end

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_on && !load_evt |=> $stable(act));
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import tmr_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRE_W    = 10,
  parameter int NC_DEPTH = 4,
  parameter int PWM_MIN  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [W-1:0]       wr_data,
  input  logic [2:0]         rd_addr,
  output logic [W-1:0]       rd_data,
  input  logic               ext_clk_pin,
  input  logic               cap_pin,
  output logic               cmp_out_a,
  output logic               cmp_out_b,
  output logic [N_FLAGS-1:0] irq_flags
);
  localparam int CTL_W = 11;

  function automatic logic [W-1:0] top_of(input logic [1:0] r);
    return (W'(1) << (PWM_MIN - 1 + int'(r))) - W'(1);
  endfunction

  logic [CTL_W-1:0] ctl;
  logic [W-1:0] cnt, cnt_nxt, top, cap_reg;
  logic [W-1:0] hold_a, hold_b;
  logic [N_FLAGS-1:0] flags;
  logic up, nxt_up, move_up, tick, adv, pwm_on;
  logic wr_ctl, wr_cnt, wr_ca, wr_cb, wr_flg;
  logic ovf_evt, load_evt, cap_evt, match_a, match_b, at_top, at_bot;
  clk_sel_e csel;

  assign csel   = clk_sel_e'(ctl[2:0]);
  assign pwm_on = (ctl[4:3] != 2'd0);
  assign top    = top_of(ctl[4:3]);

  assign wr_ctl = wr_en && (wr_addr == A_CTL);
  assign wr_cnt = wr_en && (wr_addr == A_CNT);
  assign wr_ca  = wr_en && (wr_addr == A_CMPA);
  assign wr_cb  = wr_en && (wr_addr == A_CMPB);
  assign wr_flg = wr_en && (wr_addr == A_FLG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= wr_data[CTL_W-1:0];
  end

  tmr_clk_gen #(.PRE_W(PRE_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .sel(csel), .ext_pin(ext_clk_pin), .tick(tick)
  );

  assign adv    = tick && !wr_cnt;
  assign at_top = up && (cnt >= top);
  assign at_bot = !up && (cnt == '0);

  always_comb begin
    if (!pwm_on) begin
      cnt_nxt = cnt + 1'b1;
      nxt_up  = 1'b1;
      move_up = 1'b1;
    end else if (up) begin
      cnt_nxt = at_top ? top - 1'b1 : cnt + 1'b1;
      nxt_up  = !at_top;
      move_up = !at_top;
    end else begin
      cnt_nxt = at_bot ? W'(1) : cnt - 1'b1;
      nxt_up  = at_bot;
      move_up = at_bot;
    end
  end

  assign ovf_evt  = adv && (pwm_on ? at_bot : (cnt == {W{1'b1}}));
  assign load_evt = adv && pwm_on && up && (cnt_nxt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      if (wr_cnt)   cnt <= wr_data;
      else if (adv) cnt <= cnt_nxt;
      if (!pwm_on)  up <= 1'b1;
      else if (adv) up <= nxt_up;
    end
  end

  tmr_cmp_chan #(.W(W)) u_cha (
    .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .wr_cmp(wr_ca), .wr_data(wr_data),
    .load_evt(load_evt), .adv(adv), .cnt_nxt(cnt_nxt), .move_up(move_up),
    .mode(ctl[6:5]), .match(match_a), .out_pin(cmp_out_a), .hold_val(hold_a)
  );

  tmr_cmp_chan #(.W(W)) u_chb (
    .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .wr_cmp(wr_cb), .wr_data(wr_data),
    .load_evt(load_evt), .adv(adv), .cnt_nxt(cnt_nxt), .move_up(move_up),
    .mode(ctl[8:7]), .match(match_b), .out_pin(cmp_out_b), .hold_val(hold_b)
  );

  tmr_capture #(.NC_DEPTH(NC_DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .nc_en(ctl[10]),
    .edge_rise(ctl[9]), .trig(cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_reg <= '0;
    else if (cap_evt) cap_reg <= cnt;
  end

  logic [N_FLAGS-1:0] set_vec, clr_vec;
  always_comb begin
    set_vec = '0;
    set_vec[FL_OVF]  = ovf_evt;
    set_vec[FL_CMPA] = match_a;
    set_vec[FL_CMPB] = match_b;
    set_vec[FL_CAP]  = cap_evt;
    clr_vec = wr_flg ? wr_data[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_vec | (flags & ~clr_vec);
  end
  assign irq_flags = flags;

  always_comb begin
    unique case (rd_addr)
      A_CTL:   rd_data = W'(ctl);
      A_CNT:   rd_data = cnt;
      A_CMPA:  rd_data = hold_a;
      A_CMPB:  rd_data = hold_b;
      A_CAP:   rd_data = cap_reg;
      A_FLG:   rd_data = W'(flags);
      default: rd_data = '0;
    endcase
  end

  // R4 R7
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[FL_OVF]);
  // R5
  pwm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_on && !wr_cnt && !wr_ctl && (cnt <= top) |=> cnt <= top);
  // R9
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_reg == $past(cnt)) && flags[FL_CAP]);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flg && wr_data[FL_CAP] && !cap_evt |=> !flags[FL_CAP]);
endmodule

// File: tb/test_pwm_timer16.sv
module test_pwm_timer16;
  import tmr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic ext_clk_pin = 1'b0, cap_pin = 1'b0;
  logic cmp_out_a, cmp_out_b;
  logic [3:0] irq_flags;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_timer16 i_pwm_timer16 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin),
    .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b), .irq_flags(irq_flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), v);
      chk(v == 16'h0, "R1 register", v, 0);
    end
    chk({cmp_out_a, cmp_out_b, irq_flags} == 6'b0, "R1 outputs", {cmp_out_a, cmp_out_b, irq_flags}, 0);
  endtask

  task automatic t_clock_select;
    logic [15:0] v, v2;
    wreg(A_CNT, 16'h0);
    wreg(A_CTL, 16'h0001);
    cyc(100);
    wreg(A_CTL, 16'h0000);
    rreg(A_CNT, v);
    chk(v >= 99 && v <= 103, "R2 system clock", v, 100);
    cyc(50);
    rreg(A_CNT, v2);
    chk(v2 == v, "R2 stop", v2, v);
    wreg(A_CNT, 16'h0);
    wreg(A_CTL, 16'h0002);
    cyc(800);
    wreg(A_CTL, 16'h0000);
    rreg(A_CNT, v);
    chk(v >= 99 && v <= 101, "R2 div8", v, 100);
    wreg(A_CNT, 16'h0);
    wreg(A_CTL, 16'h0003);
    cyc(640);
    wreg(A_CTL, 16'h0000);
    rreg(A_CNT, v);
    chk(v >= 9 && v <= 11, "R2 div64", v, 10);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_pin = 1'b1; cyc(4);
      ext_clk_pin = 1'b0; cyc(4);
    end
    cyc(6);
  endtask

  task automatic t_ext_clock;
    logic [15:0] v;
    wreg(A_CNT, 16'h0);
    wreg(A_CTL, 16'h0007);
    ext_pulses(10);
    wreg(A_CTL, 16'h0000);
    rreg(A_CNT, v);
    chk(v == 10, "R3 rising edges", v, 10);
    wreg(A_CNT, 16'h0);
    wreg(A_CTL, 16'h0006);
    ext_pulses(7);
    wreg(A_CTL, 16'h0000);
    rreg(A_CNT, v);
    chk(v == 7, "R3 falling edges", v, 7);
  endtask

  task automatic t_normal_mode;
    wreg(A_CTL, 16'h01A0);
    wreg(A_CMPA, 16'h0010);
    wreg(A_CMPB, 16'h0005);
    wreg(A_CNT, 16'h0);
    wreg(A_FLG, 16'h000F);
    wreg(A_CTL, 16'h01A1);
    cyc(20);
    wreg(A_CTL, 16'h01A0);
    chk(irq_flags[2:1] == 2'b11, "R4 compare flags", irq_flags, 4'h6);
    chk(cmp_out_a == 1'b1, "R4 toggle output", cmp_out_a, 1);
    chk(cmp_out_b == 1'b1, "R4 set output", cmp_out_b, 1);
    chk(irq_flags[0] == 1'b0, "R4 no overflow yet", irq_flags[0], 0);
    wreg(A_CNT, 16'hFFF0);
    wreg(A_CTL, 16'h0001);
    cyc(20);
    wreg(A_CTL, 16'h0000);
    chk(irq_flags[0] == 1'b1, "R4 overflow on wrap", irq_flags[0], 1);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wreg(A_CTL, 16'h0200);
    wreg(A_CNT, 16'h1234);
    wreg(A_FLG, 16'h000F);
    cap_pin = 1'b1; cyc(8);
    rreg(A_CAP, v);
    chk(v == 16'h1234, "R9 rising capture value", v, 16'h1234);
    chk(irq_flags[3] == 1'b1, "R9 capture flag", irq_flags[3], 1);
    cap_pin = 1'b0; cyc(8);
    wreg(A_CTL, 16'h0000);
    wreg(A_CNT, 16'h0ABC);
    wreg(A_FLG, 16'h000F);
    cap_pin = 1'b1; cyc(8);
    chk(irq_flags[3] == 1'b0, "R9 wrong edge ignored", irq_flags[3], 0);
    cap_pin = 1'b0; cyc(8);
    rreg(A_CAP, v);
    chk(v == 16'h0ABC, "R9 falling capture value", v, 16'h0ABC);
  endtask

  task automatic t_noise_cancel;
    logic [15:0] v;
    wreg(A_CTL, 16'h0600);
    cyc(8);
    wreg(A_CNT, 16'h0777);
    wreg(A_FLG, 16'h000F);
    cap_pin = 1'b1; cyc(2);
    cap_pin = 1'b0; cyc(10);
    rreg(A_CAP, v);
    chk(irq_flags[3] == 1'b0, "R10 short pulse flag", irq_flags[3], 0);
    chk(v == 16'h0ABC, "R10 short pulse value", v, 16'h0ABC);
    cap_pin = 1'b1; cyc(10);
    rreg(A_CAP, v);
    chk(v == 16'h0777, "R10 steady pulse captured", v, 16'h0777);
    cap_pin = 1'b0; cyc(10);
  endtask

  task automatic t_flag_clear;
    wreg(A_CTL, 16'h0000);
    wreg(A_CNT, 16'hFFFE);
    wreg(A_CTL, 16'h0001);
    cyc(4);
    wreg(A_CTL, 16'h0000);
    chk(irq_flags[3] && irq_flags[0], "R11 setup flags", irq_flags, 4'h9);
    wreg(A_FLG, 16'h0000);
    chk(irq_flags[3] && irq_flags[0], "R11 zero write keeps", irq_flags, 4'h9);
    wreg(A_FLG, 16'h0008);
    chk(!irq_flags[3] && irq_flags[0], "R11 one write clears", irq_flags, 4'h1);
  endtask

  task automatic t_pwm_top(input logic [15:0] ctl_stop, input logic [15:0] start,
                           input logic [15:0] topv, input string tag);
    logic [15:0] v;
    logic [15:0] mx = '0;
    wreg(A_CTL, 16'h0000);
    wreg(A_CTL, ctl_stop);
    wreg(A_CNT, start);
    wreg(A_CTL, ctl_stop | 16'h0001);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      rreg(A_CNT, v);
      if (v > mx) mx = v;
    end
    wreg(A_CTL, ctl_stop);
    rreg(A_CNT, v);
    chk(mx == topv, {tag, " peak equals TOP"}, mx, topv);
    chk(v < topv && v >= topv - 16'd20, {tag, " turned down"}, v, topv - 16'd15);
  endtask

  task automatic t_buffered;
    logic [15:0] v;
    wreg(A_CTL, 16'h0000);
    wreg(A_CMPA, 16'h0040);
    wreg(A_CTL, 16'h0048);
    wreg(A_CNT, 16'h0030);
    wreg(A_CMPA, 16'h0020);
    rreg(A_CMPA, v);
    chk(v == 16'h0020, "R6 holding readback", v, 16'h20);
    wreg(A_FLG, 16'h000F);
    wreg(A_CTL, 16'h0049);
    cyc(20);
    chk(irq_flags[1] == 1'b1, "R6 old value still active", irq_flags[1], 1);
    chk(cmp_out_a == 1'b0, "R8 cleared on up match", cmp_out_a, 0);
    wreg(A_FLG, 16'h000F);
    cyc(392);
    rreg(A_CNT, v);
    chk(irq_flags[1] == 1'b0 && v > 16'h20 && v < 16'h40, "R6 old value retired at TOP", irq_flags[1], 0);
    cyc(32);
    chk(irq_flags[1] == 1'b1, "R6 new value matches", irq_flags[1], 1);
    chk(cmp_out_a == 1'b1, "R8 set on down match", cmp_out_a, 1);
  endtask

  task automatic t_pwm_ovf;
    wreg(A_CTL, 16'h0000);
    wreg(A_CTL, 16'h0008);
    wreg(A_CNT, 16'h0080);
    wreg(A_FLG, 16'h000F);
    wreg(A_CTL, 16'h0009);
    cyc(140);
    chk(irq_flags[0] == 1'b0, "R7 no overflow at TOP", irq_flags[0], 0);
    cyc(260);
    chk(irq_flags[0] == 1'b1, "R7 overflow at BOTTOM", irq_flags[0], 1);
  endtask

  task automatic t_duty;
    int ha = 0, hb = 0;
    wreg(A_CTL, 16'h0000);
    wreg(A_CMPA, 16'h0040);
    wreg(A_CMPB, 16'h0040);
    wreg(A_CNT, 16'h0000);
    wreg(A_CTL, 16'h01C9);
    cyc(600);
    for (int i = 0; i < 510; i++) begin
      @(negedge clk);
      ha += int'(cmp_out_a);
      hb += int'(cmp_out_b);
    end
    chk(ha == 128, "R8 non-inverted duty", ha, 128);
    chk(hb == 382, "R8 inverted duty", hb, 382);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_clock_select();
    t_ext_clock();
    t_normal_mode();
    t_capture();
    t_noise_cancel();
    t_flag_clear();
    t_pwm_top(16'h0008, 16'h00F0, 16'h00FF, "R5 8-bit");
    t_pwm_top(16'h0010, 16'h01F0, 16'h01FF, "R5 9-bit");
    t_pwm_top(16'h0018, 16'h03F0, 16'h03FF, "R5 10-bit");
    t_buffered();
    t_pwm_ovf();
    t_duty();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule